// File: doc/BRIEF.md
# Wide Flit Serializer and Deserializer for a Narrow Ring Channel

This block carries one wide flit across a narrow side channel. The transmit half takes a 64-bit flit and a 6-bit destination through a valid/ready handshake. It then emits twelve 8-bit units back to back: first a head unit that names the destination and claims the path, then eleven data units. The last data unit is marked as the tail. One unit is sent per cycle, qualified by a valid strobe.

The receive half watches a channel of the same format and has a node address of its own. It locks onto a head unit that carries that address and gathers the data units that follow. When the tail arrives it rebuilds the flit and reports it with a single-cycle valid pulse. Frames sent to other nodes pass by without effect. Malformed framing is reported on an error pulse, and any partly gathered flit is dropped.

Only one source talks to one destination at a time, and every transfer moves in one ring direction. The two halves have separate channel ports. A ring stop can therefore loop them, chain them or feed them from elsewhere.

Top module: `flit_ring_link`

## Requirements
- R1: A channel unit is 8 bits. Bits [7:6] are the kind code: 2'b10 for head, 2'b00 for body, 2'b01 for tail, and 2'b11 is reserved. Bits [5:0] hold the address in a head unit and payload in the other kinds. The transmitter never emits the reserved code.
- R2: Each accepted flit produces exactly twelve valid units in consecutive cycles. They are one head carrying the destination, then ten body units, then one tail. The head appears in the cycle after the handshake.
- R3: Data unit k (k = 0 for the first unit after the head, up to k = 10 for the tail) carries flit bits [6k+5:6k]. In the tail unit, field bits [5:4] are zero.
- R4: in_ready is high when the transmitter is idle or is sending its tail unit, so frames can follow each other with no gap. tx_valid is low when no frame is in progress.
- R5: A head whose field equals node_addr, followed by ten body units and a tail, makes out_valid high for exactly one cycle. That cycle is the one after the tail is taken. out_flit then holds the rebuilt flit, and frame_err stays low.
- R6: A head addressed to another node, and the body and tail units that follow it, produce neither out_valid nor frame_err. Units with rx_valid low are ignored.
- R7: A body or tail unit that arrives when no frame is open raises frame_err for one cycle, in the cycle after it is taken. It produces no output.
- R8: A head that arrives while a frame is open raises frame_err and drops the partial data. The new head then opens a frame by its own address.
- R9: Any of the following raises frame_err, drops the frame without output and returns the receiver to idle: a tail after a number of body units other than ten in an own frame, an eleventh body unit in an own frame, or a unit with the reserved code.
- R10: After reset, in_ready is high, and tx_valid, out_valid and frame_err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| node_addr | input | 6 | Address this receiver answers to |
| in_valid | input | 1 | Flit offered to the transmitter |
| in_ready | output | 1 | Transmitter accepts the offered flit |
| in_flit | input | 64 | Flit to send |
| in_dest | input | 6 | Destination address for the flit |
| tx_valid | output | 1 | Outgoing unit valid |
| tx_unit | output | 8 | Outgoing unit |
| rx_valid | input | 1 | Incoming unit valid |
| rx_unit | input | 8 | Incoming unit |
| out_valid | output | 1 | One-cycle pulse with a rebuilt flit |
| out_flit | output | 64 | Rebuilt flit |
| frame_err | output | 1 | One-cycle framing error pulse |

## Verification
The bench builds the block with its default widths: a 64-bit flit over 6-bit fields. Because 64 is not a multiple of 6, the frame needs eleven data units with two padding bits. This makes the tail padding and the exact ten-body count boundary visible on real frames. With the channel looped back, the bench compares back-to-back frames against a behavioural model. It then drives the receive channel directly to cover orphan units, early and late tails, surplus bodies, a head arriving mid-flit and the reserved code.

// File: rtl/flit_link_pkg.sv
package flit_link_pkg;

    localparam int FLIT_W  = 64;
    localparam int FIELD_W = 6;
    localparam int ADDR_W  = FIELD_W;
    localparam int KIND_W  = 2;
    localparam int UNIT_W  = KIND_W + FIELD_W;
    localparam int DATA_N  = (FLIT_W + FIELD_W - 1) / FIELD_W;
    localparam int UNITS_N = DATA_N + 1;
    localparam int PAD_W   = DATA_N * FIELD_W;
    localparam int CNT_W   = $clog2(UNITS_N + 1);

    typedef enum logic [KIND_W-1:0] {
        UK_BODY = 2'b00,
        UK_TAIL = 2'b01,
        UK_HEAD = 2'b10,
        UK_RSVD = 2'b11
    } ukind_e;

    typedef struct packed {
        ukind_e               kind;
        logic [FIELD_W-1:0]   field;
    } unit_t;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_MINE,
        RX_PASS
    } rx_state_e;

    function automatic unit_t mk_unit(ukind_e k, logic [FIELD_W-1:0] f);
        unit_t u;
        u.kind  = k;
        u.field = f;
        return u;
    endfunction

endpackage

// File: rtl/flit_frame_tx.sv
module flit_frame_tx
    import flit_link_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [FLIT_W-1:0]  in_flit,
    input  logic [ADDR_W-1:0]  in_dest,
    output logic               tx_valid,
    output logic [UNIT_W-1:0]  tx_unit
);

    logic               busy_q;
    logic [CNT_W-1:0]   idx_q;
    logic [ADDR_W-1:0]  dest_q;
    logic [PAD_W-1:0]   pay_q;
    logic               last_w;
    logic               take_w;
    unit_t              unit_w;

    assign last_w   = busy_q && (idx_q == CNT_W'(UNITS_N - 1));
    assign in_ready = !busy_q || last_w;
    assign take_w   = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
            dest_q <= '0;
            pay_q  <= '0;
        end else if (take_w) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
            dest_q <= in_dest;
            pay_q  <= PAD_W'(in_flit);
        end else if (busy_q) begin
            if (last_w) begin
                busy_q <= 1'b0;
            end
            idx_q <= idx_q + 1'b1;
            if (idx_q != '0) begin
                pay_q <= pay_q >> FIELD_W;
            end
        end
    end

    always_comb begin
        if (idx_q == '0) begin
            unit_w = mk_unit(UK_HEAD, dest_q);
        end else if (last_w) begin
            unit_w = mk_unit(UK_TAIL, pay_q[FIELD_W-1:0]);
        end else begin
            unit_w = mk_unit(UK_BODY, pay_q[FIELD_W-1:0]);
        end
    end

    assign tx_valid = busy_q;
    assign tx_unit  = unit_w;

    AST_HEAD_AFTER_TAKE: assert property (@(posedge clk) disable iff (rst)
        take_w |=> (tx_valid && tx_unit[UNIT_W-1 -: KIND_W] == UK_HEAD)); // R2
    AST_TAIL_CLOSES: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_unit[UNIT_W-1 -: KIND_W] == UK_TAIL)
        |=> (!tx_valid || tx_unit[UNIT_W-1 -: KIND_W] == UK_HEAD)); // R2
    AST_NO_RSVD_OUT: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> (tx_unit[UNIT_W-1 -: KIND_W] != UK_RSVD)); // R1
    AST_BLOCKED_NOT_TAIL: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !in_ready) |-> (tx_unit[UNIT_W-1 -: KIND_W] != UK_TAIL)); // R4

endmodule

// File: rtl/flit_frame_rx.sv
module flit_frame_rx
    import flit_link_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  node_addr,
    input  logic               rx_valid,
    input  logic [UNIT_W-1:0]  rx_unit,
    output logic               out_valid,
    output logic [FLIT_W-1:0]  out_flit,
    output logic               frame_err
);

    unit_t              u_w;
    rx_state_e          state_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [FIELD_W-1:0] slot_q [DATA_N];
    logic [PAD_W-1:0]   asm_w;
    logic               body_ok_w;
    logic               tail_ok_w;
    logic               wr_w;
    logic               out_valid_q;
    logic [FLIT_W-1:0]  out_flit_q;
    logic               err_q;

    assign u_w = unit_t'(rx_unit);

    assign body_ok_w = rx_valid && (state_q == RX_MINE) && (u_w.kind == UK_BODY)
                       && (cnt_q < CNT_W'(DATA_N - 1));
    assign tail_ok_w = rx_valid && (state_q == RX_MINE) && (u_w.kind == UK_TAIL)
                       && (cnt_q == CNT_W'(DATA_N - 1));
    assign wr_w      = body_ok_w || tail_ok_w;

    for (genvar s = 0; s < DATA_N; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q[s] <= '0;
            end else if (wr_w && (cnt_q == CNT_W'(s))) begin
                slot_q[s] <= u_w.field;
            end
        end
        if (s == DATA_N - 1) begin : g_last
            assign asm_w[s*FIELD_W +: FIELD_W] = tail_ok_w ? u_w.field : slot_q[s];
        end else begin : g_mid
            assign asm_w[s*FIELD_W +: FIELD_W] = slot_q[s];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= RX_IDLE;
            cnt_q       <= '0;
            out_valid_q <= 1'b0;
            out_flit_q  <= '0;
            err_q       <= 1'b0;
        end else begin
            out_valid_q <= 1'b0;
            err_q       <= 1'b0;
            if (rx_valid) begin
                case (u_w.kind)
                    UK_HEAD: begin
                        err_q   <= (state_q != RX_IDLE);
                        state_q <= (u_w.field == node_addr) ? RX_MINE : RX_PASS;
                        cnt_q   <= '0;
                    end
                    UK_BODY: begin
                        if (state_q == RX_IDLE) begin
                            err_q <= 1'b1;
                        end else if (state_q == RX_MINE) begin
                            if (body_ok_w) begin
                                cnt_q <= cnt_q + 1'b1;
                            end else begin
                                err_q   <= 1'b1;
                                state_q <= RX_IDLE;
                            end
                        end
                    end
                    UK_TAIL: begin
                        if (state_q == RX_IDLE) begin
                            err_q <= 1'b1;
                        end else if (state_q == RX_MINE) begin
                            if (tail_ok_w) begin
                                out_valid_q <= 1'b1;
                                out_flit_q  <= asm_w[FLIT_W-1:0];
                            end else begin
                                err_q <= 1'b1;
                            end
                        end
                        state_q <= RX_IDLE;
                    end
                    default: begin
                        err_q   <= 1'b1;
                        state_q <= RX_IDLE;
                    end
                endcase
            end
        end
    end

    assign out_valid = out_valid_q;
    assign out_flit  = out_flit_q;
    assign frame_err = err_q;

    AST_OUT_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid); // R5
    AST_ORPHAN_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && state_q == RX_IDLE && (u_w.kind == UK_BODY || u_w.kind == UK_TAIL))
        |=> (frame_err && !out_valid)); // R7
    AST_HEAD_MIDFLIT: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && state_q != RX_IDLE && u_w.kind == UK_HEAD)
        |=> (frame_err && !out_valid)); // R8
    AST_PASS_SILENT: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && state_q == RX_PASS && (u_w.kind == UK_BODY || u_w.kind == UK_TAIL))
        |=> (!frame_err && !out_valid)); // R6
    AST_ERR_EXCLUDES_OUT: assert property (@(posedge clk) disable iff (rst)
        !(out_valid && frame_err)); // R9

endmodule

// File: rtl/flit_ring_link.sv
module flit_ring_link
    import flit_link_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  node_addr,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [FLIT_W-1:0]  in_flit,
    input  logic [ADDR_W-1:0]  in_dest,
    output logic               tx_valid,
    output logic [UNIT_W-1:0]  tx_unit,
    input  logic               rx_valid,
    input  logic [UNIT_W-1:0]  rx_unit,
    output logic               out_valid,
    output logic [FLIT_W-1:0]  out_flit,
    output logic               frame_err
);

    flit_frame_tx u_tx (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_flit  (in_flit),
        .in_dest  (in_dest),
        .tx_valid (tx_valid),
        .tx_unit  (tx_unit)
    );

    flit_frame_rx u_rx (
        .clk       (clk),
        .rst       (rst),
        .node_addr (node_addr),
        .rx_valid  (rx_valid),
        .rx_unit   (rx_unit),
        .out_valid (out_valid),
        .out_flit  (out_flit),
        .frame_err (frame_err)
    );

endmodule

// File: tb/flit_ring_link_bench.sv
module flit_ring_link_bench;
    import flit_link_pkg::*;

    localparam int DN = (FLIT_W + FIELD_W - 1) / FIELD_W;
    localparam logic [5:0] NODE = 6'h15;

    logic clk, rst;
    logic in_valid, in_ready;
    logic [63:0] in_flit;
    logic [5:0]  in_dest;
    logic tx_valid;
    logic [7:0] tx_unit;
    logic rx_valid;
    logic [7:0] rx_unit;
    logic out_valid, frame_err;
    logic [63:0] out_flit;
    logic loop_en, drv_valid;
    logic [7:0] drv_unit;

    assign rx_valid = loop_en ? tx_valid : drv_valid;
    assign rx_unit  = loop_en ? tx_unit  : drv_unit;

    flit_ring_link u_flit_ring_link (
        .clk(clk), .rst(rst), .node_addr(NODE),
        .in_valid(in_valid), .in_ready(in_ready), .in_flit(in_flit), .in_dest(in_dest),
        .tx_valid(tx_valid), .tx_unit(tx_unit),
        .rx_valid(rx_valid), .rx_unit(rx_unit),
        .out_valid(out_valid), .out_flit(out_flit), .frame_err(frame_err)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int err_n = 0;
    int got_n = 0;
    logic [63:0] got_flit = '0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // behavioural reference model, compared every cycle
    logic [7:0]   txq[$];
    int           m_mode = 0;
    int           m_cnt = 0;
    logic [127:0] m_acc = '0;
    bit           e_ov = 0, e_err = 0;
    logic [63:0]  e_flit = '0;

    always @(negedge clk) begin
        logic [7:0] e;
        logic [5:0] f;
        if (rst) begin
            txq.delete();
            m_mode = 0; m_cnt = 0; m_acc = '0; e_ov = 0; e_err = 0;
        end else begin
            if (out_valid) begin got_n++; got_flit = out_flit; end
            if (frame_err) err_n++;
            // transmit side
            if (txq.size() > 0) begin
                e = txq.pop_front();
                check(tx_valid == 1'b1 && tx_unit == e, "R2/R3", "tx unit",
                      {55'd0, tx_valid, tx_unit}, {56'd1, e});
            end else begin
                check(tx_valid == 1'b0, "R4", "tx idle", 64'(tx_valid), 64'd0);
            end
            check(in_ready == (txq.size() == 0), "R4", "in_ready",
                  64'(in_ready), 64'(txq.size() == 0));
            if (in_valid && in_ready) begin
                txq.push_back({2'b10, in_dest});
                for (int k = 0; k < DN; k++) begin
                    f = 6'(in_flit >> (FIELD_W * k));
                    txq.push_back({(k == DN - 1) ? 2'b01 : 2'b00, f});
                end
            end
            // receive side
            check(out_valid == e_ov, "R5", "out_valid", 64'(out_valid), 64'(e_ov));
            check(frame_err == e_err, "R7/R8/R9", "frame_err", 64'(frame_err), 64'(e_err));
            if (e_ov) check(out_flit == e_flit, "R5", "out_flit", out_flit, e_flit);
            e_ov = 0; e_err = 0;
            if (rx_valid) begin
                f = rx_unit[5:0];
                case (rx_unit[7:6])
                    2'b10: begin
                        if (m_mode != 0) e_err = 1;
                        m_mode = (f == NODE) ? 1 : 2;
                        m_cnt = 0; m_acc = '0;
                    end
                    2'b00: begin
                        if (m_mode == 0) e_err = 1;
                        else if (m_mode == 1) begin
                            if (m_cnt < DN - 1) begin
                                m_acc |= 128'(f) << (FIELD_W * m_cnt);
                                m_cnt++;
                            end else begin
                                e_err = 1; m_mode = 0;
                            end
                        end
                    end
                    2'b01: begin
                        if (m_mode == 0) e_err = 1;
                        else if (m_mode == 1) begin
                            if (m_cnt == DN - 1) begin
                                m_acc |= 128'(f) << (FIELD_W * m_cnt);
                                e_ov = 1; e_flit = m_acc[63:0];
                            end else e_err = 1;
                        end
                        m_mode = 0;
                    end
                    default: begin e_err = 1; m_mode = 0; end
                endcase
            end
        end
    end

    task automatic put(input logic [63:0] f, input logic [5:0] d);
        in_valid = 1'b1; in_flit = f; in_dest = d;
        do @(negedge clk); while (!in_ready);
        @(posedge clk); #2;
    endtask

    task automatic inj(input logic [1:0] k, input logic [5:0] f);
        drv_valid = 1'b1; drv_unit = {k, f};
        @(posedge clk); #2;
    endtask

    task automatic idle(input int n);
        drv_valid = 1'b0;
        repeat (n) @(posedge clk);
        #2;
    endtask

    bit done = 0;
    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int e0, g0;
        logic [63:0] xf;
        logic [5:0] v;
        rst = 1; in_valid = 0; in_flit = '0; in_dest = '0;
        loop_en = 1; drv_valid = 0; drv_unit = '0;
        repeat (3) @(posedge clk);
        #2 rst = 0;
        @(negedge clk);
        // R10 reset state
        check(in_ready && !tx_valid && !out_valid && !frame_err, "R10", "reset state",
              {60'd0, in_ready, tx_valid, out_valid, frame_err}, 64'h8);
        @(posedge clk); #2;

        // R5 own flit over loopback
        g0 = got_n; e0 = err_n;
        put(64'h0123_4567_89AB_CDEF, NODE); in_valid = 0;
        idle(16);
        check(got_n == g0 + 1, "R5", "own flit count", 64'(got_n), 64'(g0 + 1));
        check(got_flit == 64'h0123_4567_89AB_CDEF, "R5", "own flit data",
              got_flit, 64'h0123_4567_89AB_CDEF);

        // R6 flit for another node passes silently
        g0 = got_n;
        put(64'hDEAD_BEEF_0000_FFFF, 6'h2A); in_valid = 0;
        idle(16);
        check(got_n == g0 && err_n == e0, "R6", "foreign frame silent",
              64'(got_n + err_n), 64'(g0 + e0));

        // R2/R4 back-to-back frames, R3 padding with top bits set
        g0 = got_n;
        put(64'hFFFF_FFFF_FFFF_FFFF, NODE);
        put(64'hAAAA_5555_AAAA_5555, NODE);
        put(64'h8000_0000_0000_0001, NODE);
        in_valid = 0;
        idle(40);
        check(got_n == g0 + 3, "R2", "back-to-back count", 64'(got_n), 64'(g0 + 3));
        check(got_flit == 64'h8000_0000_0000_0001, "R3", "last flit",
              got_flit, 64'h8000_0000_0000_0001);

        // direct drive of the receive channel
        loop_en = 0;
        // R7 orphan body and tail
        e0 = err_n; g0 = got_n;
        inj(2'b00, 6'h01); inj(2'b01, 6'h02);
        idle(3);
        check(err_n == e0 + 2 && got_n == g0, "R7", "orphan units",
              64'(err_n - e0), 64'd2);

        // R8 head mid-flit discards partial data
        e0 = err_n; g0 = got_n;
        inj(2'b10, NODE);
        for (int k = 0; k < 3; k++) inj(2'b00, 6'h3F);
        inj(2'b10, NODE);
        xf = '0;
        for (int k = 0; k < DN; k++) begin
            v = 6'(k * 7 + 3);
            xf |= 64'(v) << (FIELD_W * k);
            inj((k == DN - 1) ? 2'b01 : 2'b00, v);
        end
        idle(3);
        check(err_n == e0 + 1, "R8", "head mid-flit error", 64'(err_n - e0), 64'd1);
        check(got_n == g0 + 1 && got_flit == xf, "R8", "restarted flit", got_flit, xf);

        // R9 early tail, surplus body, reserved code
        e0 = err_n; g0 = got_n;
        inj(2'b10, NODE);
        for (int k = 0; k < 5; k++) inj(2'b00, 6'h11);
        inj(2'b01, 6'h00);
        idle(2);
        check(err_n == e0 + 1 && got_n == g0, "R9", "early tail", 64'(err_n - e0), 64'd1);
        inj(2'b10, NODE);
        for (int k = 0; k < DN; k++) inj(2'b00, 6'h22);
        inj(2'b01, 6'h00);
        idle(2);
        check(err_n == e0 + 3 && got_n == g0, "R9", "surplus body", 64'(err_n - e0), 64'd3);
        inj(2'b11, 6'h00);
        idle(2);
        check(err_n == e0 + 4 && got_n == g0, "R9", "reserved code", 64'(err_n - e0), 64'd4);

        // R6 invalid units ignored
        e0 = err_n;
        drv_unit = 8'h40;
        idle(4);
        check(err_n == e0 && got_n == g0, "R6", "invalid units ignored",
              64'(err_n - e0), 64'd0);
        // R1 field positions after an ignored-unit stretch
        inj(2'b10, NODE);
        for (int k = 0; k < DN; k++) inj((k == DN - 1) ? 2'b01 : 2'b00, 6'h01);
        idle(3);
        xf = '0;
        for (int k = 0; k < DN; k++) xf |= 64'(1) << (FIELD_W * k);
        check(got_flit == xf, "R1", "field placement", got_flit, xf);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule